// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Interface

This block is the device-side serial port of a sigma-delta converter. It acts as an SPI slave in mode 3 (clock idles high, bits sampled on the rising edge, most significant bit first). The port inputs are brought into the system clock domain by a synchronizer, and their edges are detected there. Each access begins with an 8-bit command byte. The command byte picks one of eight register addresses and the direction of the next transfer. The block then moves the number of bits that the chosen register holds. The converter core, which is outside this block, delivers each new result on a parallel bus with a one-cycle valid strobe. The block keeps that result, its flags and a ready indication.

The serial data-out pin has two roles. While the port waits for a command with chip-select low, it shows the ready flag, so a host can wait for it to fall before it reads. The host can also enter a streaming mode in which every 24 or 32 clocks return the latest result with no command byte. The port has two ways back to a clean command boundary without a system reset: a long run of ones on the data-in pin, or chip-select going high.

Top module: `sdadc_spi_regif`

## Requirements
- R1: A command byte whose bit 7 is 1 is discarded. The port stays in the command phase, so the next 8 bits are taken as a new command. In a valid command, bit 6 = 1 means read and 0 means write, bits 5:3 are the address, and bit 2 requests streaming.
- R2: Transfer length depends on the address. Addresses 0, 4 and 5 move 8 bits. Addresses 1, 2, 6 and 7 move 24 bits. Address 3 moves 24 bits, or 32 bits when the append bit is set (see R6).
- R3: Addresses 1, 2, 6 and 7 are 24-bit read/write registers and address 5 is an 8-bit read/write register. They come out of reset at their parameter values, appear on their output ports, and a read returns the last value written. A write to address 0 only keeps the port in the command phase.
- R4: Write data sent to address 3 (result) or address 4 (identity) is discarded. Both registers read back unchanged afterwards.
- R5: A read of address 0 returns a status byte. Bit 7 is not-ready, bit 6 is the error flag, bit 5 is the missing-reference flag, bit 4 is the XOR of the 24 result bits, bit 3 is 0, and bits 2:0 are the channel number of the result.
- R6: When bit 20 of the address-1 register is 1, a result read is 32 bits: the 24-bit result followed by the status byte.
- R7: Address 4 reads as 0 in its upper nibble and as the DEV_CODE parameter in its lower nibble.
- R8: While chip-select is high, data-out is 1. While chip-select is low and the port waits for a command, data-out equals the not-ready flag.
- R9: A result strobe sampled at clock edge k drives not-ready high after edge k. After edge k+1 the result register holds the new value and not-ready is low. Not-ready also goes high when a result read (single or streamed) completes.
- R10: Command 0x5C enters streaming. Each later word returns the latest result (the same length rule as R2), and not-ready shows on data-out between words. When the first 8 data-in bits of a word are 0x58, the word ends and the port returns to the command phase.
- R11: RST_ONES (48) consecutive ones on data-in, with chip-select low, return the port to the start of a command byte in any phase. Register contents are kept.
- R12: Chip-select going high aborts a partial command, write or stream. No register changes, and the next access starts with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out; shows the ready flag when idle |
| res_valid | input | 1 | One-cycle strobe for a new conversion result |
| res_data | input | 24 | Conversion result |
| res_err | input | 1 | Over/underrange flag of the result |
| res_noref | input | 1 | Missing-reference flag of the result |
| res_chan | input | 3 | Channel number of the result |
| mode_q | output | 24 | Address-1 register |
| conf_q | output | 24 | Address-2 register |
| offset_q | output | 24 | Address-6 register |
| fscale_q | output | 24 | Address-7 register |
| outctl_q | output | 8 | Address-5 register |

## Verification
A bit counter that is off by one leaves the port out of step with the host for good. The next command byte is then decoded from shifted bits, so the read-back of the identity register that follows every streaming exit, every ones-run reset and every abort returns a wrong value within one byte. A wrong length choice, or a register write that lands where it should not, shows in the per-clock comparison of the register outputs against the bench model as soon as chip-select goes high. The ready flag is checked in the exact clock after each result strobe, and again on data-out between streamed words, so a ready path that is a cycle late or fails to clear shows up at once.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

   localparam int REG_W   = 24;
   localparam int BYTE_W  = 8;
   localparam int FRAME_W = REG_W + BYTE_W;

   localparam logic [2:0] A_STAT  = 3'd0;
   localparam logic [2:0] A_MODE  = 3'd1;
   localparam logic [2:0] A_CONF  = 3'd2;
   localparam logic [2:0] A_DATA  = 3'd3;
   localparam logic [2:0] A_IDENT = 3'd4;
   localparam logic [2:0] A_OCTL  = 3'd5;
   localparam logic [2:0] A_OFFS  = 3'd6;
   localparam logic [2:0] A_FSCL  = 3'd7;

   localparam logic [7:0] STREAM_EXIT = 8'h58;
   localparam int         APPEND_BIT  = 20;

   typedef enum logic [1:0] {PH_CMD, PH_XFER, PH_STREAM} phase_t;

   function automatic int unsigned reg_bits(input logic [2:0] addr, input logic append);
      case (addr)
         A_STAT, A_IDENT, A_OCTL: return BYTE_W;
         A_DATA:                  return append ? FRAME_W : REG_W;
         default:                 return REG_W;
      endcase
   endfunction

endpackage

// File: rtl/sdadc_pin_sync.sv
module sdadc_pin_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic csn_q,
   output logic mosi_q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdadc_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES:0]   sclk_p;
   logic [STAGES-1:0] csn_p;
   logic [STAGES-1:0] mosi_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= '1;
         csn_p  <= '1;
         mosi_p <= '0;
      end else begin
         sclk_p <= {sclk_p[STAGES-1:0], sclk_i};
         csn_p  <= {csn_p[STAGES-2:0], csn_i};
         mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
      end
   end

   assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
   assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
   assign csn_q     = csn_p[STAGES-1];
   assign mosi_q    = mosi_p[STAGES-1];

endmodule

// File: rtl/sdadc_ones_watch.sv
module sdadc_ones_watch #(
   parameter int RUN = 48
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bit_stb,
   input  logic bit_val,
   output logic fire
);
   localparam int CW = $clog2(RUN + 1);

   if (RUN < 16) begin : g_bad_run
      $error("sdadc_ones_watch: RUN must be at least 16");
   end

   logic [CW-1:0] run_cnt;

   assign fire = bit_stb & bit_val & (run_cnt == CW'(RUN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_cnt <= '0;
      else if (clr)          run_cnt <= '0;
      else if (bit_stb) begin
         if (!bit_val)       run_cnt <= '0;
         else if (run_cnt != CW'(RUN - 1)) run_cnt <= run_cnt + CW'(1);
      end
   end

   p_run_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CW'(RUN - 1));
   p_zero_breaks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !bit_val && !clr) |=> (run_cnt == '0));

endmodule

// File: rtl/sdadc_result_hold.sv
module sdadc_result_hold #(
   parameter int DW  = 24,
   parameter int CHW = 3
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           res_valid,
   input  logic [DW-1:0]  res_data,
   input  logic           res_err,
   input  logic           res_noref,
   input  logic [CHW-1:0] res_chan,
   input  logic           consume,
   output logic [DW-1:0]  dat_q,
   output logic           err_q,
   output logic           noref_q,
   output logic           par_q,
   output logic [CHW-1:0] chan_q,
   output logic           rdy_n
);
   logic           pend;
   logic [DW-1:0]  pend_d;
   logic           pend_e, pend_n;
   logic [CHW-1:0] pend_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0; pend_d <= '0; pend_e <= 1'b0; pend_n <= 1'b0; pend_c <= '0;
         dat_q <= '0; err_q <= 1'b0; noref_q <= 1'b0; par_q <= 1'b0; chan_q <= '0;
         rdy_n <= 1'b1;
      end else begin
         pend <= res_valid;
         if (res_valid) begin
            pend_d <= res_data; pend_e <= res_err; pend_n <= res_noref; pend_c <= res_chan;
         end
         if (pend) begin
            dat_q <= pend_d; err_q <= pend_e; noref_q <= pend_n; chan_q <= pend_c;
            par_q <= ^pend_d;
         end
         if (res_valid)    rdy_n <= 1'b1;
         else if (pend)    rdy_n <= 1'b0;
         else if (consume) rdy_n <= 1'b1;
      end
   end

   p_warn_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> rdy_n);
   p_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !res_valid) |=> !rdy_n);
   p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> $stable(dat_q));

endmodule

// File: rtl/sdadc_cfg_regs.sv
module sdadc_cfg_regs
   import sdadc_pkg::*;
#(
   parameter int           W    = 24,
   parameter int           OW   = 8,
   parameter logic [W-1:0] R_MD = '0,
   parameter logic [W-1:0] R_CF = '0,
   parameter logic [W-1:0] R_OF = '0,
   parameter logic [W-1:0] R_FS = '0,
   parameter logic [OW-1:0] R_OC = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [W-1:0]  wr_data,
   output logic [W-1:0]  mode_q,
   output logic [W-1:0]  conf_q,
   output logic [W-1:0]  ofs_q,
   output logic [W-1:0]  fs_q,
   output logic [OW-1:0] octl_q
);
   localparam int NSLOT = 4;
   localparam logic [2:0]   SLOT_ADDR [NSLOT] = '{A_MODE, A_CONF, A_OFFS, A_FSCL};
   localparam logic [W-1:0] SLOT_RST  [NSLOT] = '{R_MD, R_CF, R_OF, R_FS};

   if (OW > W) begin : g_bad_ow
      $error("sdadc_cfg_regs: OW must not exceed W");
   end

   logic [W-1:0] slot_q [NSLOT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NSLOT; k++) slot_q[k] <= SLOT_RST[k];
         octl_q <= R_OC;
      end else if (wr_en) begin
         for (int k = 0; k < NSLOT; k++)
            if (wr_addr == SLOT_ADDR[k]) slot_q[k] <= wr_data;
         if (wr_addr == A_OCTL) octl_q <= wr_data[OW-1:0];
      end
   end

   assign mode_q = slot_q[0];
   assign conf_q = slot_q[1];
   assign ofs_q  = slot_q[2];
   assign fs_q   = slot_q[3];

   p_ro_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == A_DATA || wr_addr == A_IDENT || wr_addr == A_STAT))
      |=> ($stable(mode_q) && $stable(conf_q) && $stable(ofs_q) && $stable(fs_q) && $stable(octl_q)));
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(mode_q) && $stable(conf_q) && $stable(octl_q)));

endmodule

// File: rtl/sdadc_spi_regif.sv
module sdadc_spi_regif
   import sdadc_pkg::*;
#(
   parameter logic [3:0]       DEV_CODE    = 4'hA,
   parameter int               SYNC_STAGES = 2,
   parameter int               RST_ONES    = 48,
   parameter logic [REG_W-1:0] MODE_RST    = 24'h080060,
   parameter logic [REG_W-1:0] CONF_RST    = 24'h000117,
   parameter logic [REG_W-1:0] OFS_RST     = 24'h800000,
   parameter logic [REG_W-1:0] FS_RST      = 24'h5A0000,
   parameter logic [BYTE_W-1:0] OCTL_RST   = 8'h00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              res_valid,
   input  logic [REG_W-1:0]  res_data,
   input  logic              res_err,
   input  logic              res_noref,
   input  logic [2:0]        res_chan,
   output logic [REG_W-1:0]  mode_q,
   output logic [REG_W-1:0]  conf_q,
   output logic [REG_W-1:0]  offset_q,
   output logic [REG_W-1:0]  fscale_q,
   output logic [BYTE_W-1:0] outctl_q
);
   localparam int BCW = $clog2(FRAME_W + 1);

   logic rise, fall, csn_q, mosi_q, fire;
   logic [REG_W-1:0] dat_q;
   logic err_q, noref_q, par_q, rdy_n;
   logic [2:0] chan_q;

   phase_t           phase;
   logic [BCW-1:0]   bcnt, cur_len;
   logic [REG_W-2:0] rx;
   logic [FRAME_W-1:0] tx, tx_src;
   logic             loaded, cur_rd, wr_en, consume;
   logic [2:0]       cur_addr;
   logic [REG_W-1:0] wr_data;
   logic [7:0]       stat_byte, cmd_byte;

   sdadc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .csn_i(spi_cs_n), .mosi_i(spi_mosi),
      .sclk_rise(rise), .sclk_fall(fall), .csn_q(csn_q), .mosi_q(mosi_q));

   sdadc_ones_watch #(.RUN(RST_ONES)) i_ones (
      .clk(clk), .rst_n(rst_n), .clr(csn_q), .bit_stb(rise), .bit_val(mosi_q), .fire(fire));

   sdadc_result_hold #(.DW(REG_W), .CHW(3)) i_hold (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .res_err(res_err), .res_noref(res_noref), .res_chan(res_chan), .consume(consume),
      .dat_q(dat_q), .err_q(err_q), .noref_q(noref_q), .par_q(par_q), .chan_q(chan_q),
      .rdy_n(rdy_n));

   sdadc_cfg_regs #(.W(REG_W), .OW(BYTE_W), .R_MD(MODE_RST), .R_CF(CONF_RST),
                    .R_OF(OFS_RST), .R_FS(FS_RST), .R_OC(OCTL_RST)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cur_addr), .wr_data(wr_data),
      .mode_q(mode_q), .conf_q(conf_q), .ofs_q(offset_q), .fs_q(fscale_q), .octl_q(outctl_q));

   assign stat_byte = {rdy_n, err_q, noref_q, par_q, 1'b0, chan_q};
   assign cmd_byte  = {rx[6:0], mosi_q};

   always_comb begin
      case (cur_addr)
         A_STAT:  tx_src = {stat_byte, {REG_W{1'b0}}};
         A_MODE:  tx_src = {mode_q, {BYTE_W{1'b0}}};
         A_CONF:  tx_src = {conf_q, {BYTE_W{1'b0}}};
         A_DATA:  tx_src = {dat_q, stat_byte};
         A_IDENT: tx_src = {4'h0, DEV_CODE, {REG_W{1'b0}}};
         A_OCTL:  tx_src = {outctl_q, {REG_W{1'b0}}};
         A_OFFS:  tx_src = {offset_q, {BYTE_W{1'b0}}};
         default: tx_src = {fscale_q, {BYTE_W{1'b0}}};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CMD; bcnt <= '0; cur_len <= BCW'(BYTE_W); rx <= '0; tx <= '0;
         loaded <= 1'b0; cur_rd <= 1'b0; cur_addr <= '0;
         wr_en <= 1'b0; wr_data <= '0; consume <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         consume <= 1'b0;
         if (csn_q || fire) begin
            phase <= PH_CMD; bcnt <= '0; loaded <= 1'b0;
         end else begin
            if (fall && phase != PH_CMD && cur_rd && bcnt == '0 && !loaded) begin
               tx <= tx_src; loaded <= 1'b1;
            end
            if (rise) begin
               rx <= {rx[REG_W-3:0], mosi_q};
               if (loaded) tx <= tx << 1;
               case (phase)
                  PH_CMD: begin
                     if (bcnt == BCW'(7)) begin
                        bcnt <= '0;
                        if (!cmd_byte[7]) begin
                           cur_addr <= cmd_byte[5:3];
                           cur_rd   <= cmd_byte[6];
                           cur_len  <= BCW'(reg_bits(cmd_byte[5:3], mode_q[APPEND_BIT]));
                           if (cmd_byte[6] && cmd_byte[5:3] == A_DATA && cmd_byte[2])
                              phase <= PH_STREAM;
                           else if (!cmd_byte[6] && cmd_byte[5:3] == A_STAT)
                              phase <= PH_CMD;
                           else
                              phase <= PH_XFER;
                        end
                     end else bcnt <= bcnt + BCW'(1);
                  end
                  PH_XFER: begin
                     if (bcnt == cur_len - BCW'(1)) begin
                        phase <= PH_CMD; bcnt <= '0; loaded <= 1'b0;
                        if (!cur_rd) begin
                           wr_en <= 1'b1; wr_data <= {rx, mosi_q};
                        end else if (cur_addr == A_DATA) consume <= 1'b1;
                     end else bcnt <= bcnt + BCW'(1);
                  end
                  default: begin
                     if (bcnt == BCW'(7) && cmd_byte == STREAM_EXIT) begin
                        phase <= PH_CMD; bcnt <= '0; loaded <= 1'b0;
                     end else if (bcnt == cur_len - BCW'(1)) begin
                        bcnt <= '0; loaded <= 1'b0; consume <= 1'b1;
                     end else bcnt <= bcnt + BCW'(1);
                  end
               endcase
            end
         end
      end
   end

   assign spi_miso = (spi_cs_n || csn_q) ? 1'b1 :
                     loaded              ? tx[FRAME_W-1] :
                     (phase == PH_XFER)  ? 1'b1 : rdy_n;

   p_bad_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD && rise && bcnt == BCW'(7) && rx[6] && !csn_q && !fire)
      |=> (phase == PH_CMD && bcnt == '0));
   p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_CMD) |-> (bcnt < cur_len));
   p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STREAM && rise && bcnt == BCW'(7) && cmd_byte == STREAM_EXIT && !csn_q && !fire)
      |=> (phase == PH_CMD));
   p_run_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !csn_q) |=> (phase == PH_CMD && bcnt == '0 && !loaded));
   p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      csn_q |=> (phase == PH_CMD && !loaded && !wr_en));

endmodule

// File: tb/test_sdadc_spi_regif.sv
module test_sdadc_spi_regif;
   localparam int HALF = 6;
   localparam logic [3:0] DEV = 4'hA;
   localparam logic [7:0] ID_EXP = {4'h0, DEV};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
   logic res_valid = 1'b0, res_err = 1'b0, res_noref = 1'b0;
   logic [23:0] res_data = '0;
   logic [2:0]  res_chan = '0;
   wire spi_miso;
   wire [23:0] mode_o, conf_o, ofs_o, fs_o;
   wire [7:0]  octl_o;

   sdadc_spi_regif i_sdadc_spi_regif (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(csn), .spi_mosi(mosi),
      .spi_miso(spi_miso), .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
      .res_noref(res_noref), .res_chan(res_chan), .mode_q(mode_o), .conf_q(conf_o),
      .offset_q(ofs_o), .fscale_q(fs_o), .outctl_q(octl_o));

   int checks = 0, fails = 0;
   bit cmp_en = 1'b0, done = 1'b0;

   // behavioural model
   logic [23:0] m_mode = 24'h080060, m_conf = 24'h000117, m_ofs = 24'h800000, m_fs = 24'h5A0000;
   logic [7:0]  m_octl = 8'h00;
   logic [23:0] m_dat = '0;
   logic m_err = 1'b0, m_noref = 1'b0, m_rdy_n = 1'b1;
   logic [2:0] m_chan = '0;

   function automatic logic [7:0] m_stat();
      return {m_rdy_n, m_err, m_noref, ^m_dat, 1'b0, m_chan};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of register outputs against the model (R3)
   always @(negedge clk) if (cmp_en) begin
      chk("R3 mode", {8'h0, mode_o}, {8'h0, m_mode});
      chk("R3 conf", {8'h0, conf_o}, {8'h0, m_conf});
      chk("R3 offset", {8'h0, ofs_o}, {8'h0, m_ofs});
      chk("R3 fscale", {8'h0, fs_o}, {8'h0, m_fs});
      chk("R3 outctl", {24'h0, octl_o}, {24'h0, m_octl});
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_lo();
      cmp_en = 1'b0; @(negedge clk); csn = 1'b0; wait_n(4);
   endtask

   task automatic cs_hi();
      @(negedge clk); sclk = 1'b1; wait_n(2); csn = 1'b1; wait_n(8);
   endtask

   task automatic shift(input int n, input logic [31:0] dout, output logic [31:0] din);
      din = '0;
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); sclk = 1'b0; mosi = dout[i];
         wait_n(HALF);
         din[i] = spi_miso;
         sclk = 1'b1;
         wait_n(HALF);
      end
   endtask

   task automatic wr(input logic [2:0] a, input int w, input logic [23:0] v);
      logic [31:0] d;
      cs_lo();
      shift(8, {24'h0, 2'b00, a, 3'b000}, d);
      shift(w, {8'h0, v}, d);
      cs_hi();
      case (a)
         3'd1: m_mode = v;
         3'd2: m_conf = v;
         3'd5: m_octl = v[7:0];
         3'd6: m_ofs = v;
         3'd7: m_fs = v;
         default: ;
      endcase
      cmp_en = 1'b1;
   endtask

   task automatic rd(input logic [2:0] a, input int w, output logic [31:0] v);
      logic [31:0] d;
      cs_lo();
      shift(8, {24'h0, 2'b01, a, 3'b000}, d);
      shift(w, 32'h0, v);
      cs_hi();
      cmp_en = 1'b1;
   endtask

   task automatic push(input logic [23:0] dv, input logic e, input logic nr, input logic [2:0] c);
      @(negedge clk); res_valid = 1'b1; res_data = dv; res_err = e; res_noref = nr; res_chan = c;
      @(negedge clk); res_valid = 1'b0;
      m_dat = dv; m_err = e; m_noref = nr; m_chan = c; m_rdy_n = 1'b0;
      wait_n(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, d;
      logic [7:0] es;
      wait_n(10);
      rst_n = 1'b1;
      wait_n(3);
      cmp_en = 1'b1;
      chk("R8 miso high with cs high", {31'h0, spi_miso}, 32'h1);

      // R5 status after reset: not ready, no flags
      rd(3'd0, 8, v);  chk("R5 status reset", v, 32'h80);
      // R7 identity
      rd(3'd4, 8, v);  chk("R7 ident", v, {24'h0, ID_EXP});
      // R2/R3 reset value read over 24 bits
      rd(3'd1, 24, v); chk("R2 mode read width", v, {8'h0, m_mode});

      // R3 writes and read-back
      wr(3'd1, 24, 24'h0A1234);
      wr(3'd2, 24, 24'h3C5A96);
      wr(3'd6, 24, 24'h7FFFF0);
      wr(3'd7, 24, 24'h123456);
      wr(3'd5, 8, 24'h00005C);
      rd(3'd2, 24, v); chk("R3 conf readback", v, {8'h0, m_conf});
      rd(3'd6, 24, v); chk("R3 offset readback", v, {8'h0, m_ofs});
      rd(3'd7, 24, v); chk("R3 fscale readback", v, {8'h0, m_fs});
      rd(3'd5, 8, v);  chk("R3 outctl readback", v, {24'h0, m_octl});

      // R8 ready visible on miso, R9 exact timing
      push(24'hABC123, 1'b1, 1'b0, 3'd5);
      cs_lo();
      chk("R8 miso shows ready", {31'h0, spi_miso}, 32'h0);
      @(negedge clk); res_valid = 1'b1; res_data = 24'h00F00F; res_err = 1'b0; res_noref = 1'b1; res_chan = 3'd2;
      @(negedge clk); res_valid = 1'b0;
      chk("R9 not-ready one cycle before update", {31'h0, spi_miso}, 32'h1);
      @(negedge clk);
      chk("R9 ready after update", {31'h0, spi_miso}, 32'h0);
      m_dat = 24'h00F00F; m_err = 1'b0; m_noref = 1'b1; m_chan = 3'd2; m_rdy_n = 1'b0;
      cs_hi(); cmp_en = 1'b1;

      // R5 status fields
      es = m_stat();
      rd(3'd0, 8, v); chk("R5 status fields", v, {24'h0, es});
      // R2 data read 24 bits, then R9 ready cleared
      rd(3'd3, 24, v); chk("R2 data 24-bit", v, {8'h0, m_dat});
      m_rdy_n = 1'b1;
      rd(3'd0, 8, v); chk("R9 read clears ready", v, {24'h0, m_stat()});

      // R4 read-only registers ignore writes
      wr(3'd3, 24, 24'h555555);
      wr(3'd4, 8, 24'h0000FF);
      rd(3'd3, 24, v); chk("R4 data unchanged", v, {8'h0, m_dat});
      rd(3'd4, 8, v);  chk("R4 ident unchanged", v, {24'h0, ID_EXP});

      // R6 status append
      wr(3'd1, 24, 24'h1A1234);
      push(24'h13579B, 1'b0, 1'b0, 3'd7);
      es = m_stat();
      rd(3'd3, 32, v); chk("R6 appended frame", v, {m_dat, es});
      m_rdy_n = 1'b1;
      wr(3'd1, 24, 24'h0A1234);

      // R1 invalid command byte discarded
      cs_lo();
      shift(8, 32'hC8, d);
      shift(8, 32'h60, d);
      shift(8, 32'h0, v);
      cs_hi(); cmp_en = 1'b1;
      chk("R1 invalid command ignored", v, {24'h0, ID_EXP});

      // R10 streaming
      push(24'h2468AC, 1'b0, 1'b0, 3'd1);
      cs_lo();
      shift(8, 32'h5C, d);
      for (int w = 0; w < 3; w++) begin
         if (w > 0) push(24'h100000 + 24'(w * 24'h01F3), 1'b0, 1'b0, 3'(w));
         wait_n(3);
         chk("R10 ready between words", {31'h0, spi_miso}, 32'h0);
         shift(24, 32'h0, v);
         chk("R10 streamed word", v, {8'h0, m_dat});
         m_rdy_n = 1'b1;
         chk("R10 not-ready after word", {31'h0, spi_miso}, 32'h1);
      end
      shift(8, {24'h0, 8'h58}, d);
      shift(8, 32'h60, d);
      shift(8, 32'h0, v);
      cs_hi(); cmp_en = 1'b1;
      chk("R10 exit code returns to command", v, {24'h0, ID_EXP});

      // R12 abort of a partial write and a partial command
      cs_lo();
      shift(8, 32'h10, d);
      shift(12, 32'hFFF, d);
      cs_hi(); cmp_en = 1'b1;
      rd(3'd2, 24, v); chk("R12 aborted write no effect", v, {8'h0, m_conf});
      cs_lo();
      shift(5, 32'h0A, d);
      cs_hi(); cmp_en = 1'b1;
      rd(3'd4, 8, v); chk("R12 next access after abort", v, {24'h0, ID_EXP});

      // R11 run of ones resets the port, registers kept
      cs_lo();
      shift(4, 32'h4, d);
      shift(24, 32'hFFFFFF, d);
      shift(24, 32'hFFFFFF, d);
      shift(8, 32'h60, d);
      shift(8, 32'h0, v);
      chk("R11 aligned after ones run", v, {24'h0, ID_EXP});
      shift(8, 32'h48, d);
      shift(24, 32'h0, v);
      cs_hi(); cmp_en = 1'b1;
      chk("R11 mode kept", v, {8'h0, m_mode});
      chk("R8 miso high after cs", {31'h0, spi_miso}, 32'h1);

      wait_n(5);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule